// File: doc/BRIEF.md
# Line-Granular Region Buffer

This block is the central pixel store of an image pipeline. It keeps a sliding window of whole image lines around the current region of interest. Pixels arrive four at a time as packed words and are written into a fill line that is still being built. A commit strobe appends the finished line to the retained window. A release strobe retires the oldest retained line. The window therefore behaves as a first-in first-out queue whose entries are complete lines. Any word inside the window can be read at random at any time.

Storage is a set of single-port RAM banks. Consecutive words of a line rotate across the banks. Control has two layers. A bank layer steers each cycle's write and read onto the banks and settles collisions in favour of the write. A pointer layer keeps the head line, the fill line and the line count. It also turns a window-relative line number into a physical line on the circular store, which holds one line more than the window.

Top module: `line_region_buf`

## Requirements
- R1: After reset the line count is 0, `empty` is 1, `full` is 0, `rd_valid` is 0, and both reject pulses are 0.
- R2: A `line_commit` while the count is below LINES raises the count by one on the next cycle. `full` is 1 exactly when the count equals LINES.
- R3: A `line_commit` while the count equals LINES is refused. The count stays unchanged, and `commit_rej` is 1 for the single following cycle.
- R4: A `line_release` while the count is 0 is ignored. The count stays 0, and `release_rej` is 1 for the single following cycle.
- R5: A `line_release` with a non-zero count retires the oldest line. Afterwards, relative line 0 addresses the line that was previously relative line 1.
- R6: A read is accepted when `rd_req` and `rd_ready` are both 1 and `rd_line` is below the count. One cycle after acceptance, `rd_valid` is 1 and `rd_data` holds the word last written at column `rd_col` of the line that is `rd_line` places after the oldest one. A word packs four horizontally adjacent pixels, with pixel k at bits [k*PIX_W +: PIX_W].
- R7: `wr_en` writes `wr_data` at column `wr_col` of the fill line. That line is not part of the window until it is committed, so reads at relative line = count return no `rd_valid`. Words written before the commit are read back after it.
- R8: When `wr_en` is 1 and an in-window read targets the bank of the write, `rd_ready` is 0 in that cycle. The read is not performed, so `rd_valid` is 0 on the next cycle, and the write still completes.
- R9: A word at column c lives in bank c mod BANKS. An in-window read whose bank differs from the bank of a same-cycle write has `rd_ready` at 1 and is served.
- R10: A read with `rd_line` greater than or equal to the count produces no `rd_valid` on the next cycle.
- R11: Physical storage is reused circularly. After many more commits than the physical capacity, every retained line still reads back its own data.
- R12: A `line_commit` and a `line_release` in the same cycle, with the window neither full nor empty, leave the count unchanged and shift the window by one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one word into the fill line |
| wr_col | input | $clog2(LINE_WORDS) | Word column of the write |
| wr_data | input | 4*PIX_W | Four packed pixels to write |
| line_commit | input | 1 | Append the fill line to the window |
| line_release | input | 1 | Retire the oldest line of the window |
| rd_req | input | 1 | Read request |
| rd_line | input | $clog2(LINES) | Line number relative to the oldest retained line |
| rd_col | input | $clog2(LINE_WORDS) | Word column of the read |
| rd_ready | output | 1 | Low when the read loses its bank to a write |
| rd_valid | output | 1 | Read data valid (one cycle after acceptance) |
| rd_data | output | 4*PIX_W | Read word |
| line_count | output | $clog2(LINES+1) | Number of retained lines |
| full | output | 1 | Window holds LINES lines |
| empty | output | 1 | Window holds no line |
| commit_rej | output | 1 | One-cycle pulse after a refused commit |
| release_rej | output | 1 | One-cycle pulse after an ignored release |

## Verification
The properties assume that callers never drive `rd_col` or `wr_col` at or beyond LINE_WORDS. They also assume that strobes and requests are held for whole clock cycles. The bank-collision properties decide in-window status from the count at the ports, so they need the count to be the only limit on readable lines. The bench meets these assumptions. It drives every input on the falling edge and keeps each column below the line width. It sweeps every relative line and every column of a small configuration, and it computes each expected word arithmetically from the line's sequence number and the column.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    localparam int PIX_PER_WORD = 4;

    typedef enum logic [1:0] {
        BANK_IDLE,
        BANK_WRITE,
        BANK_READ
    } bank_op_e;
endpackage

// File: rtl/lrb_bank.sv
module lrb_bank #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // single port: one write or one read per cycle
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/lrb_bank_ctrl.sv
module lrb_bank_ctrl import lrb_pkg::*; #(
    parameter int DATA_W     = 32,
    parameter int BANKS      = 4,
    parameter int LINE_WORDS = 16,
    parameter int PHYS       = 73,
    localparam int PTR_W  = $clog2(PHYS),
    localparam int COL_W  = $clog2(LINE_WORDS),
    localparam int BANK_W = $clog2(BANKS),
    localparam int WPB    = LINE_WORDS / BANKS,
    localparam int DEPTH  = PHYS * WPB,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_phys,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [PTR_W-1:0]  rd_phys,
    input  logic [COL_W-1:0]  rd_col,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] sel;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    logic [BANK_W-1:0] wr_bank, rd_bank;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              clash, rd_go;
    logic [DATA_W-1:0] bank_rd [BANKS];

    // low column bits pick the bank, the rest plus the line pick the word
    assign wr_bank = wr_col[BANK_W-1:0];
    assign rd_bank = rd_col[BANK_W-1:0];
    assign wr_addr = ADDR_W'(wr_phys) * ADDR_W'(WPB) + ADDR_W'(wr_col >> BANK_W);
    assign rd_addr = ADDR_W'(rd_phys) * ADDR_W'(WPB) + ADDR_W'(rd_col >> BANK_W);

    // write wins a shared bank
    assign clash    = rd_req && wr_en && (rd_bank == wr_bank);
    assign rd_go    = rd_req && !clash;
    assign rd_ready = !clash;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_op_e          op;
        logic [ADDR_W-1:0] addr;

        always_comb begin
            op = BANK_IDLE;
            if (wr_en && (wr_bank == BANK_W'(b))) begin
                op = BANK_WRITE;
            end else if (rd_go && (rd_bank == BANK_W'(b))) begin
                op = BANK_READ;
            end
            addr = (op == BANK_WRITE) ? wr_addr : rd_addr;
        end

        lrb_bank #(
            .DEPTH (DEPTH),
            .DATA_W(DATA_W)
        ) bank_i (
            .clk  (clk),
            .en   (op != BANK_IDLE),
            .we   (op == BANK_WRITE),
            .addr (addr),
            .wdata(wr_data),
            .rdata(bank_rd[b])
        );
    end

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = rd_go;
        if (rd_go) begin
            rs_d.sel = rd_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rd_valid = rs_q.valid;
    assign rd_data  = bank_rd[rs_q.sel];
endmodule

// File: rtl/lrb_line_ptrs.sv
module lrb_line_ptrs #(
    parameter int LINES = 72,
    localparam int PHYS   = LINES + 1,
    localparam int PTR_W  = $clog2(PHYS),
    localparam int CNT_W  = $clog2(LINES + 1),
    localparam int LINE_W = $clog2(LINES),
    localparam int SUM_W  = PTR_W + 1,
    localparam int CMP_W  = (CNT_W > LINE_W) ? CNT_W : LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_commit,
    input  logic              line_release,
    input  logic [LINE_W-1:0] rd_line,
    output logic [PTR_W-1:0]  wr_phys,
    output logic [PTR_W-1:0]  rd_phys,
    output logic              rd_in_win,
    output logic [CNT_W-1:0]  line_count,
    output logic              full,
    output logic              empty,
    output logic              commit_rej,
    output logic              release_rej
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
        logic             c_rej;
        logic             r_rej;
    } ptr_state_t;

    ptr_state_t ps_d, ps_q;
    logic       c_ok, r_ok;
    logic [SUM_W-1:0] sum;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(PHYS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ps_d       = ps_q;
        c_ok       = line_commit && (ps_q.cnt < CNT_W'(LINES));
        r_ok       = line_release && (ps_q.cnt != '0);
        ps_d.c_rej = line_commit && !c_ok;
        ps_d.r_rej = line_release && !r_ok;
        if (c_ok) begin
            ps_d.tail = step(ps_q.tail);
        end
        if (r_ok) begin
            ps_d.head = step(ps_q.head);
        end
        if (c_ok && !r_ok) begin
            ps_d.cnt = ps_q.cnt + 1'b1;
        end else if (r_ok && !c_ok) begin
            ps_d.cnt = ps_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    // relative line -> physical line on the circular store
    always_comb begin
        sum = SUM_W'(ps_q.head) + SUM_W'(rd_line);
        if (sum >= SUM_W'(PHYS)) begin
            sum = sum - SUM_W'(PHYS);
        end
    end

    assign rd_phys     = sum[PTR_W-1:0];
    assign rd_in_win   = CMP_W'(rd_line) < CMP_W'(ps_q.cnt);
    assign wr_phys     = ps_q.tail;
    assign line_count  = ps_q.cnt;
    assign full        = ps_q.cnt == CNT_W'(LINES);
    assign empty       = ps_q.cnt == '0;
    assign commit_rej  = ps_q.c_rej;
    assign release_rej = ps_q.r_rej;
endmodule

// File: rtl/line_region_buf.sv
module line_region_buf import lrb_pkg::*; #(
    parameter int PIX_W      = 8,
    parameter int LINE_WORDS = 16,
    parameter int LINES      = 72,
    parameter int BANKS      = 4,
    localparam int DATA_W = PIX_PER_WORD * PIX_W,
    localparam int PHYS   = LINES + 1,
    localparam int PTR_W  = $clog2(PHYS),
    localparam int COL_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = $clog2(LINES),
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_commit,
    input  logic              line_release,
    input  logic              rd_req,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [COL_W-1:0]  rd_col,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  line_count,
    output logic              full,
    output logic              empty,
    output logic              commit_rej,
    output logic              release_rej
);
    logic [PTR_W-1:0] wr_phys, rd_phys;
    logic             rd_in_win;

    lrb_line_ptrs #(
        .LINES(LINES)
    ) ptrs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_commit (line_commit),
        .line_release(line_release),
        .rd_line     (rd_line),
        .wr_phys     (wr_phys),
        .rd_phys     (rd_phys),
        .rd_in_win   (rd_in_win),
        .line_count  (line_count),
        .full        (full),
        .empty       (empty),
        .commit_rej  (commit_rej),
        .release_rej (release_rej)
    );

    lrb_bank_ctrl #(
        .DATA_W    (DATA_W),
        .BANKS     (BANKS),
        .LINE_WORDS(LINE_WORDS),
        .PHYS      (PHYS)
    ) banks_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_phys (wr_phys),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .rd_req  (rd_req && rd_in_win),
        .rd_phys (rd_phys),
        .rd_col  (rd_col),
        .rd_ready(rd_ready),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/line_region_buf_chk.sv
module line_region_buf_chk #(
    parameter int LINES  = 72,
    parameter int BANKS  = 4,
    parameter int COL_W  = 4,
    parameter int LINE_W = 7,
    parameter int CNT_W  = 7,
    localparam int BANK_W = $clog2(BANKS),
    localparam int CMP_W  = (CNT_W > LINE_W) ? CNT_W : LINE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [COL_W-1:0]  wr_col,
    input logic              line_commit,
    input logic              line_release,
    input logic              rd_req,
    input logic [LINE_W-1:0] rd_line,
    input logic [COL_W-1:0]  rd_col,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  line_count,
    input logic              full,
    input logic              empty,
    input logic              commit_rej,
    input logic              release_rej
);
    logic in_win, same_bank;
    assign in_win    = CMP_W'(rd_line) < CMP_W'(line_count);
    assign same_bank = rd_col[BANK_W-1:0] == wr_col[BANK_W-1:0];

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_count <= CNT_W'(LINES));

    assert_commit_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_commit && !full && !line_release) |=> (line_count == CNT_W'($past(line_count) + 1'b1)));

    assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_commit && full && !line_release) |=> (commit_rej && line_count == $past(line_count)));

    assert_empty_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_release && empty && !line_commit) |=> (release_rej && line_count == '0));

    assert_bank_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_en && in_win && same_bank) |-> !rd_ready);

    assert_stall_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> !rd_valid);

    assert_interleave_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_en && !same_bank) |-> rd_ready);

    assert_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_win) |=> !rd_valid);

    assert_swap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (line_commit && line_release && !full && !empty) |=> (line_count == $past(line_count)));
endmodule

bind line_region_buf line_region_buf_chk #(
    .LINES (LINES),
    .BANKS (BANKS),
    .COL_W (COL_W),
    .LINE_W(LINE_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_col      (wr_col),
    .line_commit (line_commit),
    .line_release(line_release),
    .rd_req      (rd_req),
    .rd_line     (rd_line),
    .rd_col      (rd_col),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .line_count  (line_count),
    .full        (full),
    .empty       (empty),
    .commit_rej  (commit_rej),
    .release_rej (release_rej)
);

// File: tb/line_region_buf_tb.sv
module line_region_buf_tb_top;
    localparam int PIX_W = 8;
    localparam int LW    = 8;
    localparam int NL    = 6;
    localparam int NB    = 4;
    localparam int COL_W = $clog2(LW);
    localparam int LN_W  = $clog2(NL);
    localparam int CNT_W = $clog2(NL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [COL_W-1:0] wr_col = '0;
    logic [31:0] wr_data = '0;
    logic line_commit = 1'b0;
    logic line_release = 1'b0;
    logic rd_req = 1'b0;
    logic [LN_W-1:0] rd_line = '0;
    logic [COL_W-1:0] rd_col = '0;
    logic rd_ready, rd_valid, full, empty, commit_rej, release_rej;
    logic [31:0] rd_data;
    logic [CNT_W-1:0] line_count;

    int n_cmp = 0;
    int n_bad = 0;
    int head_seq = 0;
    int cnt_m = 0;

    always #2.5 clk = ~clk;

    line_region_buf #(
        .PIX_W(PIX_W), .LINE_WORDS(LW), .LINES(NL), .BANKS(NB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
        .line_commit(line_commit), .line_release(line_release),
        .rd_req(rd_req), .rd_line(rd_line), .rd_col(rd_col),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .line_count(line_count), .full(full), .empty(empty),
        .commit_rej(commit_rej), .release_rej(release_rej)
    );

    function automatic logic [31:0] ew(input int s, input int c);
        return (32'(s) * 32'h0100_0193) ^ (32'(c) * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_count(input string req);
        chk(req, 32'(line_count), 32'(cnt_m));
        chk(req, 32'(full), 32'(cnt_m == NL));
        chk(req, 32'(empty), 32'(cnt_m == 0));
    endtask

    task automatic fill_line(input int seq);
        for (int c = 0; c < LW; c++) begin
            wr_en = 1'b1; wr_col = COL_W'(c); wr_data = ew(seq, c);
            tick();
        end
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic cm, input logic rl);
        line_commit = cm; line_release = rl;
        tick();
        line_commit = 1'b0; line_release = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int rel, input int col,
                          input logic exp_v, input logic [31:0] exp_d);
        rd_req = 1'b1; rd_line = LN_W'(rel); rd_col = COL_W'(col);
        tick();
        rd_req = 1'b0;
        chk(req, 32'(rd_valid), 32'(exp_v));
        if (exp_v) chk(req, rd_data, exp_d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_count("R1");
        chk("R1", 32'(rd_valid), 0);
        chk("R1", 32'(commit_rej), 0);
        chk("R1", 32'(release_rej), 0);

        // R4 release on empty
        strobe(1'b0, 1'b1);
        chk("R4", 32'(release_rej), 1);
        chk_count("R4");
        tick();
        chk("R4", 32'(release_rej), 0);

        // R10 read of an empty window
        rd_chk("R10", 0, 0, 1'b0, '0);

        // R7 fill line hidden before commit
        fill_line(0);
        chk_count("R7");
        rd_chk("R7", 0, 3, 1'b0, '0);

        // R2 commits up to full
        strobe(1'b1, 1'b0); cnt_m = 1;
        chk_count("R2");
        for (int s = 1; s < NL; s++) begin
            fill_line(s);
            strobe(1'b1, 1'b0); cnt_m++;
            chk_count("R2");
        end

        // R3 refused commit, fill line holds seq NL
        fill_line(NL);
        strobe(1'b1, 1'b0);
        chk("R3", 32'(commit_rej), 1);
        chk_count("R3");
        tick();
        chk("R3", 32'(commit_rej), 0);

        // R6 exhaustive read sweep
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < LW; c++)
                rd_chk("R6", l, c, 1'b1, ew(l, c));

        // R10 relative lines beyond the count
        for (int l = NL; l < (1 << LN_W); l++) rd_chk("R10", l, 1, 1'b0, '0);

        // R5 release shifts the window
        strobe(1'b0, 1'b1); cnt_m--; head_seq = 1;
        chk_count("R5");
        for (int c = 0; c < LW; c++) rd_chk("R5", 0, c, 1'b1, ew(1, c));
        rd_chk("R10", cnt_m, 0, 1'b0, '0);

        // R7 data written before the commit appears after it
        strobe(1'b1, 1'b0); cnt_m++;
        chk_count("R7");
        for (int c = 0; c < LW; c++) rd_chk("R7", NL - 1, c, 1'b1, ew(NL, c));

        // R8 / R9 bank arbitration, fill line seq NL+1
        strobe(1'b0, 1'b1); cnt_m--; head_seq = 2;
        for (int c = 2; c < LW; c++) begin
            wr_en = 1'b1; wr_col = COL_W'(c); wr_data = ew(NL + 1, c);
            tick();
        end
        for (int k = 0; k < NB; k++) begin
            // write col 1 every pass; read col 1+NB stalls, col k shares a bank only when k==1
            wr_en = 1'b1; wr_col = 1; wr_data = ew(NL + 1, 1);
            rd_req = 1'b1; rd_line = 0; rd_col = COL_W'((k == 0) ? 1 + NB : k);
            #1;
            chk((k == 0 || k == 1) ? "R8" : "R9", 32'(rd_ready), 32'(!(k == 0 || k == 1)));
            tick();
            wr_en = 1'b0; rd_req = 1'b0;
            if (k == 0 || k == 1) chk("R8", 32'(rd_valid), 0);
            else begin
                chk("R9", 32'(rd_valid), 1);
                chk("R9", rd_data, ew(2, k));
            end
        end
        wr_en = 1'b1; wr_col = 0; wr_data = ew(NL + 1, 0);
        rd_req = 1'b1; rd_line = 1; rd_col = 3;
        #1 chk("R9", 32'(rd_ready), 1);
        tick();
        wr_en = 1'b0; rd_req = 1'b0;
        chk("R9", rd_data, ew(3, 3));
        strobe(1'b1, 1'b0); cnt_m++;
        rd_chk("R8", NL - 1, 1, 1'b1, ew(NL + 1, 1));
        rd_chk("R8", NL - 1, 0, 1'b1, ew(NL + 1, 0));

        // R12 commit and release together
        strobe(1'b0, 1'b1); cnt_m--; head_seq = 3;
        fill_line(NL + 2);
        strobe(1'b1, 1'b1); head_seq = 4;
        chk_count("R12");
        rd_chk("R12", 0, 0, 1'b1, ew(4, 0));
        rd_chk("R12", cnt_m - 1, LW - 1, 1'b1, ew(NL + 2, LW - 1));

        // R11 many laps of the circular store
        for (int it = 0; it < 4 * (NL + 1); it++) begin
            fill_line(NL + 3 + it);
            strobe(1'b1, 1'b1); head_seq++;
            if (it % 3 == 0) begin
                chk_count("R11");
                for (int c = 0; c < LW; c += 3) begin
                    rd_chk("R11", 0, c, 1'b1, ew(head_seq, c));
                    rd_chk("R11", cnt_m - 1, c, 1'b1, ew(head_seq + cnt_m - 1, c));
                end
            end
        end

        // drain to empty, then one more release
        while (cnt_m > 0) begin
            rd_chk("R5", 0, 2, 1'b1, ew(head_seq, 2));
            strobe(1'b0, 1'b1); cnt_m--; head_seq++;
            chk_count("R5");
        end
        strobe(1'b0, 1'b1);
        chk("R4", 32'(release_rej), 1);
        chk_count("R4");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule